// File: doc/BRIEF.md
# Packed SIMD Saturating ALU

This block is a 64-bit packed-integer arithmetic unit. One operand word is split at run time into eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes, chosen for each operation. Every lane is computed on its own, and no carry or borrow crosses from one lane into the next. The unit covers the following operations:

- add and subtract, with a choice of wraparound, signed clamping or unsigned clamping
- the three lane shifts
- the four bitwise operations
- lane compares that return all-ones or all-zeros masks
- a 16-bit lane multiply and a pairwise multiply-accumulate
- a narrowing pack with saturation
- interleaving unpacks that take the low or the high half of both operands

A caller presents two operand words, an operation code, a lane-size code and a saturation code, together with an input valid. One clock later the result appears on a registered output with its own valid. When the input valid is low, the output word keeps its last value.

Top module: `simd_sat_alu`

## Requirements
- R1: `res_valid` equals `in_valid` from one clock earlier, and `res_data` loads the result only in cycles where `in_valid` is high, otherwise holding its value. After reset both outputs are zero.
- R2: The lane-size code selects the lane width: 0 is 8 bits, 1 is 16 bits, and 2 or 3 is 32 bits. Add (opcode 0) and subtract (opcode 1) with saturation code 0 or 3 wrap modulo 2^w inside each lane, with no carry between lanes.
- R3: Saturation code 1 clamps each signed add or subtract lane result to 2^(w-1)-1 on positive overflow and to -2^(w-1) on negative overflow.
- R4: Saturation code 2 clamps each unsigned add lane result to all ones, and each unsigned subtract lane result to zero when it would go below zero.
- R5: Shift-left-logical (opcode 2), shift-right-logical (opcode 3) and shift-right-arithmetic (opcode 4) shift every lane by the count in `op_b[5:0]`. A count of w or more gives 0 for the logical shifts and a fill with the lane's sign bit for the arithmetic shift.
- R6: AND (5), AND-NOT (6, computed as ~A & B), OR (7) and XOR (8) act on the full word, whatever the lane-size code.
- R7: Compare-equal (11) and signed compare-greater-than A > B (12) set each lane to all ones when the test is true and to all zeros when it is false.
- R8: Multiply (9) always uses four 16-bit lanes, whatever the lane-size code, and keeps the low 16 bits of each product.
- R9: Multiply-add (10) forms signed 16x16 products of lanes 2j and 2j+1 and writes their sum, modulo 2^32, into 32-bit lane j.
- R10: Pack (13) works as follows:
  - With lane-size code 1 it narrows 16-bit lanes to 8 bits; with code 2 or 3 it narrows 32-bit lanes to 16 bits; with code 0 it gives zero.
  - The narrowed lanes of A fill the low half of the result and those of B fill the high half.
  - Values are signed-saturated, except under saturation code 2, where signed inputs are clamped to the range 0 to 2^n-1.
- R11: Unpack-low (14) and unpack-high (15) take the lanes of the low half (14) or the high half (15) of A and B. Lane i of A goes to result lane 2i and lane i of B goes to result lane 2i+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| op_code | input | 4 | Operation code |
| lane_size | input | 2 | Lane width code |
| sat_mode | input | 2 | Saturation code |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| res_valid | output | 1 | Result valid, one cycle after `in_valid` |
| res_data | output | 64 | Registered result word |

## Verification
The bench builds the unit at its default word width of 64. At that width there are three lane widths, both pack directions, four 16-bit multiplier lanes and two multiply-add sums, so every lane boundary and every narrowing path is reachable.

Directed operands target the clamp limits, shift counts at and beyond the lane width, and the most-negative product pairs. A run of random operations, with idle gaps that carry junk operands, then covers carry isolation and the hold-when-idle behaviour across all opcode, size and mode combinations.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_SLL   = 4'd2,
    OP_SRL   = 4'd3,
    OP_SRA   = 4'd4,
    OP_AND   = 4'd5,
    OP_ANDN  = 4'd6,
    OP_OR    = 4'd7,
    OP_XOR   = 4'd8,
    OP_MUL   = 4'd9,
    OP_MADD  = 4'd10,
    OP_CMPEQ = 4'd11,
    OP_CMPGT = 4'd12,
    OP_PACK  = 4'd13,
    OP_UNPL  = 4'd14,
    OP_UNPH  = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    SZ_8   = 2'd0,
    SZ_16  = 2'd1,
    SZ_32  = 2'd2,
    SZ_32X = 2'd3
  } lane_size_e;

  typedef enum logic [1:0] {
    SAT_WRAP     = 2'd0,
    SAT_SIGNED   = 2'd1,
    SAT_UNSIGNED = 2'd2,
    SAT_WRAPX    = 2'd3
  } sat_mode_e;

endpackage

// File: rtl/simd_field_unit.sv
module simd_field_unit
  import simd_alu_pkg::*;
#(
  parameter int FW = 8
) (
  input  logic [FW-1:0] a,
  input  logic [FW-1:0] b,
  input  alu_op_e       op,
  input  sat_mode_e     mode,
  input  logic [5:0]    shamt,
  output logic [FW-1:0] res
);

  localparam logic [6:0]    FW_CNT = 7'(FW);
  localparam logic [FW-1:0] S_MAX  = {1'b0, {(FW-1){1'b1}}};
  localparam logic [FW-1:0] S_MIN  = {1'b1, {(FW-1){1'b0}}};

  logic [FW:0] sum;
  logic [FW:0] dif;
  logic        sovf_add;
  logic        sovf_sub;
  logic        over_range;

  always_comb begin
    sum        = {1'b0, a} + {1'b0, b};
    dif        = {1'b0, a} - {1'b0, b};
    sovf_add   = (a[FW-1] == b[FW-1]) && (sum[FW-1] != a[FW-1]);
    sovf_sub   = (a[FW-1] != b[FW-1]) && (dif[FW-1] != a[FW-1]);
    over_range = ({1'b0, shamt} >= FW_CNT);
  end

  always_comb begin
    res = '0;
    case (op)
      OP_ADD: begin
        case (mode)
          SAT_SIGNED:   res = sovf_add ? (a[FW-1] ? S_MIN : S_MAX) : sum[FW-1:0];
          SAT_UNSIGNED: res = sum[FW] ? '1 : sum[FW-1:0];
          default:      res = sum[FW-1:0];
        endcase
      end
      OP_SUB: begin
        case (mode)
          SAT_SIGNED:   res = sovf_sub ? (a[FW-1] ? S_MIN : S_MAX) : dif[FW-1:0];
          SAT_UNSIGNED: res = dif[FW] ? '0 : dif[FW-1:0];
          default:      res = dif[FW-1:0];
        endcase
      end
      OP_SLL:   res = over_range ? '0 : (a << shamt);
      OP_SRL:   res = over_range ? '0 : (a >> shamt);
      OP_SRA:   res = over_range ? {FW{a[FW-1]}} : FW'($signed(a) >>> shamt);
      OP_CMPEQ: res = {FW{a == b}};
      OP_CMPGT: res = {FW{$signed(a) > $signed(b)}};
      default:  res = '0;
    endcase
  end

endmodule

// File: rtl/simd_mul_unit.sv
module simd_mul_unit #(
  parameter int WORD_W = 64
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] mul_res,
  output logic [WORD_W-1:0] madd_res
);

  localparam int NL = WORD_W / 16;
  localparam int NP = NL / 2;

  logic signed [31:0] prod [NL];

  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign prod[i] = $signed(a[i*16 +: 16]) * $signed(b[i*16 +: 16]);
    assign mul_res[i*16 +: 16] = prod[i][15:0];
  end

  for (genvar j = 0; j < NP; j++) begin : g_pair
    assign madd_res[j*32 +: 32] = prod[2*j] + prod[2*j+1];
  end

endmodule

// File: rtl/simd_pack_unit.sv
module simd_pack_unit
  import simd_alu_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  lane_size_e        sz,
  input  logic              uns,
  output logic [WORD_W-1:0] pack_res,
  output logic [WORD_W-1:0] unpl_res,
  output logic [WORD_W-1:0] unph_res
);

  localparam int N8  = WORD_W / 8;
  localparam int N16 = WORD_W / 16;
  localparam int N32 = WORD_W / 32;
  localparam int H8  = N8 / 2;
  localparam int H16 = N16 / 2;
  localparam int H32 = N32 / 2;

  function automatic logic [7:0] nar8(input logic [15:0] v, input logic u);
    if (u)
      return v[15] ? 8'h00 : ((|v[15:8]) ? 8'hFF : v[7:0]);
    else if (v[15] && !(&v[15:7]))
      return 8'h80;
    else if (!v[15] && (|v[15:7]))
      return 8'h7F;
    else
      return v[7:0];
  endfunction

  function automatic logic [15:0] nar16(input logic [31:0] v, input logic u);
    if (u)
      return v[31] ? 16'h0000 : ((|v[31:16]) ? 16'hFFFF : v[15:0]);
    else if (v[31] && !(&v[31:15]))
      return 16'h8000;
    else if (!v[31] && (|v[31:15]))
      return 16'h7FFF;
    else
      return v[15:0];
  endfunction

  logic [WORD_W-1:0] p8, p16;
  logic [WORD_W-1:0] l8, l16, l32, h8, h16, h32;

  for (genvar i = 0; i < N16; i++) begin : g_pk8
    assign p8[i*8 +: 8]       = nar8(a[i*16 +: 16], uns);
    assign p8[(N16+i)*8 +: 8] = nar8(b[i*16 +: 16], uns);
  end

  for (genvar i = 0; i < N32; i++) begin : g_pk16
    assign p16[i*16 +: 16]       = nar16(a[i*32 +: 32], uns);
    assign p16[(N32+i)*16 +: 16] = nar16(b[i*32 +: 32], uns);
  end

  for (genvar i = 0; i < H8; i++) begin : g_up8
    assign l8[(2*i)*8 +: 8]   = a[i*8 +: 8];
    assign l8[(2*i+1)*8 +: 8] = b[i*8 +: 8];
    assign h8[(2*i)*8 +: 8]   = a[(H8+i)*8 +: 8];
    assign h8[(2*i+1)*8 +: 8] = b[(H8+i)*8 +: 8];
  end

  for (genvar i = 0; i < H16; i++) begin : g_up16
    assign l16[(2*i)*16 +: 16]   = a[i*16 +: 16];
    assign l16[(2*i+1)*16 +: 16] = b[i*16 +: 16];
    assign h16[(2*i)*16 +: 16]   = a[(H16+i)*16 +: 16];
    assign h16[(2*i+1)*16 +: 16] = b[(H16+i)*16 +: 16];
  end

  for (genvar i = 0; i < H32; i++) begin : g_up32
    assign l32[(2*i)*32 +: 32]   = a[i*32 +: 32];
    assign l32[(2*i+1)*32 +: 32] = b[i*32 +: 32];
    assign h32[(2*i)*32 +: 32]   = a[(H32+i)*32 +: 32];
    assign h32[(2*i+1)*32 +: 32] = b[(H32+i)*32 +: 32];
  end

  always_comb begin
    case (sz)
      SZ_8: begin
        pack_res = '0;
        unpl_res = l8;
        unph_res = h8;
      end
      SZ_16: begin
        pack_res = p8;
        unpl_res = l16;
        unph_res = h16;
      end
      default: begin
        pack_res = p16;
        unpl_res = l32;
        unph_res = h32;
      end
    endcase
  end

endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
  import simd_alu_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op_code,
  input  logic [1:0]        lane_size,
  input  logic [1:0]        sat_mode,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_data
);

  localparam int NSZ = 3;

  alu_op_e    op_e;
  lane_size_e sz_e;
  sat_mode_e  md_e;

  assign op_e = alu_op_e'(op_code);
  assign sz_e = lane_size_e'(lane_size);
  assign md_e = sat_mode_e'(sat_mode);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // lane datapaths, one replica per lane width
  logic [NSZ-1:0][WORD_W-1:0] lane_res;

  for (genvar s = 0; s < NSZ; s++) begin : g_sz
    localparam int FW = 8 << s;
    localparam int NF = WORD_W / FW;
    for (genvar i = 0; i < NF; i++) begin : g_lane
      simd_field_unit #(.FW(FW)) u_field (
        .a     (op_a[i*FW +: FW]),
        .b     (op_b[i*FW +: FW]),
        .op    (op_e),
        .mode  (md_e),
        .shamt (op_b[5:0]),
        .res   (lane_res[s][i*FW +: FW])
      );
    end
  end

  logic [WORD_W-1:0] mul_res, madd_res;

  simd_mul_unit #(.WORD_W(WORD_W)) u_mul (
    .a        (op_a),
    .b        (op_b),
    .mul_res  (mul_res),
    .madd_res (madd_res)
  );

  logic [WORD_W-1:0] pack_res, unpl_res, unph_res;

  simd_pack_unit #(.WORD_W(WORD_W)) u_pack (
    .a        (op_a),
    .b        (op_b),
    .sz       (sz_e),
    .uns      (md_e == SAT_UNSIGNED),
    .pack_res (pack_res),
    .unpl_res (unpl_res),
    .unph_res (unph_res)
  );

  // next-state
  logic [WORD_W-1:0] lane_sel;
  logic [WORD_W-1:0] result_d;

  always_comb begin
    case (sz_e)
      SZ_8:    lane_sel = lane_res[0];
      SZ_16:   lane_sel = lane_res[1];
      default: lane_sel = lane_res[2];
    endcase
  end

  always_comb begin
    case (op_e)
      OP_AND:  result_d = op_a & op_b;
      OP_ANDN: result_d = ~op_a & op_b;
      OP_OR:   result_d = op_a | op_b;
      OP_XOR:  result_d = op_a ^ op_b;
      OP_MUL:  result_d = mul_res;
      OP_MADD: result_d = madd_res;
      OP_PACK: result_d = pack_res;
      OP_UNPL: result_d = unpl_res;
      OP_UNPH: result_d = unph_res;
      default: result_d = lane_sel;
    endcase
  end

  // registers
  logic              valid_q;
  logic [WORD_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) data_q <= result_d;
    end
  end

  assign res_valid = valid_q;
  assign res_data  = data_q;

  // checks
  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> res_valid);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> (!res_valid && $stable(res_data)));

  assert_sat_add_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && op_e == OP_ADD && sz_e == SZ_16 && md_e == SAT_SIGNED
     && !op_a[15] && !op_b[15])
    |=> ($signed(res_data[15:0]) >= $signed($past(op_a[15:0]))));

  assert_usat_sub_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && op_e == OP_SUB && sz_e == SZ_8 && md_e == SAT_UNSIGNED)
    |=> (res_data[7:0] <= $past(op_a[7:0])));

  assert_shift_over_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && op_e == OP_SLL && op_b[5:0] >= 6'd32) |=> (res_data == '0));

  assert_cmp_mask_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && (op_e == OP_CMPEQ || op_e == OP_CMPGT) && sz_e == SZ_8)
    |=> (res_data[7:0] == 8'h00 || res_data[7:0] == 8'hFF));

endmodule

// File: tb/tb_simd_sat_alu.sv
`timescale 1ns/1ps
module tb_simd_sat_alu;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op_code;
  logic [1:0]  lane_size;
  logic [1:0]  sat_mode;
  logic [63:0] op_a, op_b;
  logic        res_valid;
  logic [63:0] res_data;

  simd_sat_alu #(.WORD_W(64)) dut (
    .clk, .rst_n, .in_valid, .op_code, .lane_size, .sat_mode,
    .op_a, .op_b, .res_valid, .res_data
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  logic [63:0] exp_q [$];
  string       tag_q [$];
  logic [63:0] last_exp = '0;
  bit          mon_on = 1'b0;
  bit          done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint clampv(input longint v, input longint lo, input longint hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic longint fld(input logic [63:0] w, input int i, input int fw);
    return longint'(w >> (i*fw)) & ((longint'(1) << fw) - 1);
  endfunction

  function automatic longint sxt(input longint x, input int fw);
    return ((x >> (fw-1)) & 1) ? x - (longint'(1) << fw) : x;
  endfunction

  function automatic string req_of(input int op, input int md);
    case (op)
      0, 1:        return (md == 1) ? "R3" : (md == 2) ? "R4" : "R2";
      2, 3, 4:     return "R5";
      5, 6, 7, 8:  return "R6";
      9:           return "R8";
      10:          return "R9";
      11, 12:      return "R7";
      13:          return "R10";
      default:     return "R11";
    endcase
  endfunction

  function automatic logic [63:0] model(input int op, input int sz, input int md,
                                        input logic [63:0] a, input logic [63:0] b);
    int w, n, sh, nw, base;
    longint mask, x, y, sx, sy, r, lo, hi, p0, p1;
    logic [63:0] res;
    res  = '0;
    w    = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    n    = 64 / w;
    mask = (longint'(1) << w) - 1;
    lo   = -(longint'(1) << (w-1));
    hi   = (longint'(1) << (w-1)) - 1;
    sh   = int'(b[5:0]);
    case (op)
      9: for (int i = 0; i < 4; i++) begin
           r = sxt(fld(a, i, 16), 16) * sxt(fld(b, i, 16), 16);
           res |= 64'(r & 64'hFFFF) << (i*16);
         end
      10: for (int j = 0; j < 2; j++) begin
            p0 = sxt(fld(a, 2*j, 16), 16) * sxt(fld(b, 2*j, 16), 16);
            p1 = sxt(fld(a, 2*j+1, 16), 16) * sxt(fld(b, 2*j+1, 16), 16);
            res |= 64'((p0 + p1) & 64'hFFFF_FFFF) << (j*32);
          end
      13: if (sz != 0) begin
            nw = w / 2;
            for (int i = 0; i < n; i++) begin
              for (int k = 0; k < 2; k++) begin
                sx = sxt(fld(k == 0 ? a : b, i, w), w);
                if (md == 2) r = clampv(sx, 0, (longint'(1) << nw) - 1);
                else         r = clampv(sx, -(longint'(1) << (nw-1)), (longint'(1) << (nw-1)) - 1);
                res |= 64'(r & ((longint'(1) << nw) - 1)) << ((k*n + i)*nw);
              end
            end
          end
      14, 15: begin
            base = (op == 15) ? n/2 : 0;
            for (int i = 0; i < n/2; i++) begin
              res |= 64'(fld(a, base+i, w)) << ((2*i)*w);
              res |= 64'(fld(b, base+i, w)) << ((2*i+1)*w);
            end
          end
      default: for (int i = 0; i < n; i++) begin
            x = fld(a, i, w); y = fld(b, i, w);
            sx = sxt(x, w);   sy = sxt(y, w);
            case (op)
              0: r = (md == 1) ? clampv(sx + sy, lo, hi) : (md == 2) ? clampv(x + y, 0, mask) : x + y;
              1: r = (md == 1) ? clampv(sx - sy, lo, hi) : (md == 2) ? clampv(x - y, 0, mask) : x - y;
              2: r = (sh >= w) ? 0 : (x << sh);
              3: r = (sh >= w) ? 0 : (x >> sh);
              4: r = (sh >= w) ? ((sx < 0) ? -1 : 0) : (sx >>> sh);
              5: r = x & y;
              6: r = ~x & y;
              7: r = x | y;
              8: r = x ^ y;
              11: r = (x == y) ? -1 : 0;
              default: r = (sx > sy) ? -1 : 0;
            endcase
            res |= 64'(r & mask) << (i*w);
          end
    endcase
    return res;
  endfunction

  // driver: one request per call, expected value pushed to the scoreboard
  task automatic send(input int op, input int sz, input int md,
                      input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    in_valid  = 1'b1;
    op_code   = 4'(op);
    lane_size = 2'(sz);
    sat_mode  = 2'(md);
    op_a = a;
    op_b = b;
    exp_q.push_back(model(op, sz, md, a, b));
    tag_q.push_back(req_of(op, md));
  endtask

  // idle cycle with junk operands that must have no effect
  task automatic idle();
    @(negedge clk);
    in_valid  = 1'b0;
    op_code   = 4'($urandom);
    lane_size = 2'($urandom);
    sat_mode  = 2'($urandom);
    op_a = {$urandom, $urandom};
    op_b = {$urandom, $urandom};
  endtask

  // monitor: pops the scoreboard on each valid result; checks hold otherwise
  always @(negedge clk) begin
    if (mon_on) begin
      if (res_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected valid", res_data, '0);
        end else begin
          logic [63:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(res_data === e, t, res_data, e);
          last_exp = e;
        end
      end else begin
        check(res_data === last_exp, "R1 hold", res_data, last_exp);
      end
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      check(1'b0, "watchdog", '0, '0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_code = '0; lane_size = '0; sat_mode = '0;
    op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(res_valid === 1'b0, "R1 reset valid", {63'b0, res_valid}, '0);
    check(res_data === '0, "R1 reset data", res_data, '0);
    mon_on = 1'b1;

    // R2: byte wrap with no carry into the neighbour lane
    send(0, 0, 0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001);
    send(1, 1, 3, 64'h0000_0001_8000_1234, 64'h0001_0002_0001_1234);
    // R3: signed clamp in 16- and 32-bit lanes
    send(0, 1, 1, 64'h7FFF_8000_0001_FFFF, 64'h0001_8000_7FFF_FFFF);
    send(1, 2, 1, 64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF);
    // R4: unsigned clamp
    send(0, 0, 2, 64'hF0F0_0102_FF80_0000, 64'h2010_0101_0180_0000);
    send(1, 1, 2, 64'h0001_0010_FFFF_0000, 64'h0002_0010_0001_0001);
    // R5: shifts, counts inside and beyond the lane
    send(2, 1, 0, 64'h8001_1234_00FF_FFFF, 64'd3);
    send(4, 0, 0, 64'h80_7F_C0_01_FF_00_81_40, 64'd9);
    send(3, 2, 0, 64'hFFFF_FFFF_8000_0000, 64'd40);
    send(2, 3, 0, 64'hDEAD_BEEF_1234_5678, 64'd32);
    send(4, 2, 0, 64'h8000_0000_7000_0000, 64'd4);
    // R6: bitwise ops
    send(5, 0, 0, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_1234_5678);
    send(6, 1, 0, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_1234_5678);
    send(7, 2, 0, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_1234_5678);
    send(8, 3, 0, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_1234_5678);
    // R7: compares
    send(11, 0, 0, 64'h01_02_03_04_05_06_07_08, 64'h01_00_03_00_05_00_07_00);
    send(12, 1, 0, 64'h8000_7FFF_0001_FFFF, 64'h7FFF_8000_0001_0000);
    // R8, R9: multiplier paths
    send(9, 0, 0, 64'h8000_7FFF_FFFF_0100, 64'h8000_0002_FFFF_0100);
    send(10, 2, 0, 64'h8000_8000_7FFF_FFFF, 64'h8000_8000_7FFF_0003);
    // R10: packs, both widths, both clamps, and the zero case
    send(13, 1, 0, 64'h0080_FF7F_007F_FF80, 64'h1234_8000_FFFF_0001);
    send(13, 2, 2, 64'h0001_0000_FFFF_FFFF, 64'h0000_8000_0000_1234);
    send(13, 0, 0, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
    // R11: interleaves
    send(14, 0, 0, 64'hA7A6_A5A4_A3A2_A1A0, 64'hB7B6_B5B4_B3B2_B1B0);
    send(15, 2, 0, 64'hA7A6_A5A4_A3A2_A1A0, 64'hB7B6_B5B4_B3B2_B1B0);
    send(15, 1, 0, 64'hA7A6_A5A4_A3A2_A1A0, 64'hB7B6_B5B4_B3B2_B1B0);

    // random sweep with idle gaps
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 3) == 0) idle();
      send($urandom_range(0, 15), $urandom_range(0, 3), $urandom_range(0, 3),
           {$urandom, $urandom}, {$urandom, $urandom});
    end

    repeat (4) idle();
    check(exp_q.size() == 0, "R1 all results seen", 64'(exp_q.size()), '0);
    check(res_valid === 1'b0, "R1 idle valid", {63'b0, res_valid}, '0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule